// File: doc/BRIEF.md
# Target Write Buffer with Disconnect Control

This block sits behind the target side of a bus interface and absorbs write data phases arriving from an external initiator. Each accepted phase is stored, with its byte enables, in a small first-in first-out buffer. The buffer then drains in order toward the internal register side through a valid/ready port. The block decides, phase by phase, whether a phase is taken and when to tell the initiator to disconnect.

Two control inputs steer a transaction. A burst-off bit picks between two disconnect policies: take phases until the buffer is full, or take exactly one phase. A swap-enable bit reverses the byte lanes of each stored word and its enables, so register accesses are seen in little-endian order instead of the default big-endian order. Both bits are sampled when the first phase of a transaction is accepted and hold for the rest of that transaction.

A transaction may only start once the buffer is empty. If a transaction opens while earlier data is still waiting, its first phase is refused with disconnect, so the initiator retries later.

Top module: `twb_top`

## Requirements
- R1: With burst-off low when the transaction starts, phases are accepted until one leaves the buffer holding DEPTH entries after any drain in that cycle. Disconnect is asserted together with that phase.
- R2: With burst-off high when the transaction starts, the first phase is accepted and disconnect is asserted in that same cycle.
- R3: After disconnect, every further phase of the same transaction, up to and including the one marked last, is refused (accept low) with disconnect high.
- R4: With swap-enable low, data and byte enables are stored and drained unchanged (big-endian). Both control bits low is the burst-allowed, big-endian setting.
- R5: With swap-enable high, byte lane k (bits 8k+7:8k) of the 32-bit word moves to lane 3-k, and byte-enable bit k moves to bit 3-k.
- R6: Stored words leave the drain port in arrival order. While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R7: The first phase of a transaction that arrives while the buffer is not empty is refused, with disconnect high. The rest of that transaction is refused as in R3.
- R8: Changing either control bit after the first phase of a transaction does not change the policy or byte order of that transaction.
- R9: A transaction whose last phase arrives before the buffer fills, with burst allowed, has every phase accepted and no disconnect.
- R10: After reset, out_valid is low, the buffer is empty, and accept and disconnect are low whenever in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_burst_off | input | 1 | 1: one data phase per transaction; 0: fill the buffer |
| cfg_swap_en | input | 1 | 1: reverse byte lanes (little-endian); 0: pass through |
| in_valid | input | 1 | A write data phase is present this cycle |
| in_last | input | 1 | This phase is the initiator's final phase of the transaction |
| in_data | input | DATA_W | Write data of the phase |
| in_be | input | DATA_W/8 | Byte enables of the phase |
| wr_acc | output | 1 | The present phase is written into the buffer |
| wr_disc | output | 1 | Disconnect signalled on the present phase |
| out_valid | output | 1 | A buffered word is available to drain |
| out_ready | input | 1 | The internal side takes the word this cycle |
| out_data | output | DATA_W | Oldest buffered data word |
| out_be | output | DATA_W/8 | Byte enables of the oldest word |

## Verification
The hardest situation to reach is a transaction opening while the buffer still holds data, since the internal side normally empties it quickly. The stimulus holds out_ready low, completes a one-phase transaction so a word stays behind, and then opens a second transaction to see the retry. A second hard case is a change of the control bits in the middle of a transaction. The driver flips both bits between phases and expects the latched policy and byte order to persist. Drain is also run in parallel with a long burst, so the buffer never fills and no disconnect may appear.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic [1:0] {
        TS_IDLE   = 2'd0,
        TS_ACTIVE = 2'd1,
        TS_IGNORE = 2'd2
    } txn_state_e;

    typedef struct packed {
        txn_state_e state;
        logic       burst_off;
        logic       swap;
    } ctrl_state_t;

endpackage

// File: rtl/twb_swap.sv
module twb_swap #(
    parameter int DATA_W = 32
) (
    input  logic                  en,
    input  logic [DATA_W-1:0]     data_i,
    input  logic [DATA_W/8-1:0]   be_i,
    output logic [DATA_W-1:0]     data_o,
    output logic [DATA_W/8-1:0]   be_o
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0]   data_rev;
    logic [LANES-1:0]    be_rev;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign data_rev[8*k +: 8]       = data_i[8*(LANES-1-k) +: 8];
        assign be_rev[k]                = be_i[LANES-1-k];
    end

    assign data_o = en ? data_rev : data_i;
    assign be_o   = en ? be_rev   : be_i;
endmodule

// File: rtl/twb_fifo.sv
module twb_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic [DATA_W/8-1:0]        push_be,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          out_data,
    output logic [DATA_W/8-1:0]        out_be,
    output logic                       pop,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int BE_W  = DATA_W / 8;
    localparam int ENT_W = DATA_W + BE_W;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            wr_ptr;
        logic [PTR_W-1:0]            rd_ptr;
        logic [CNT_W-1:0]            cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    assign out_valid = (st_q.cnt != '0);
    assign pop       = out_valid && out_ready;
    assign out_data  = st_q.mem[st_q.rd_ptr][ENT_W-1:BE_W];
    assign out_be    = st_q.mem[st_q.rd_ptr][BE_W-1:0];
    assign count     = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr_ptr] = {push_data, push_be};
            st_d.wr_ptr = (st_q.wr_ptr == PTR_END) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_END) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl
    import twb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             cfg_burst_off,
    input  logic             cfg_swap_en,
    input  logic [CNT_W-1:0] count,
    input  logic             pop,
    output logic             acc,
    output logic             disc,
    output logic             swap_sel,
    output logic             in_txn
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    ctrl_state_t st_d, st_q;
    logic        fills_up;
    logic        live_burst_off;

    // accepting now leaves the buffer at DEPTH entries
    assign fills_up = pop ? (count == FULL_CNT) : (count == LAST_SLOT);
    assign in_txn   = (st_q.state != TS_IDLE);

    always_comb begin
        st_d           = st_q;
        acc            = 1'b0;
        disc           = 1'b0;
        swap_sel       = st_q.swap;
        live_burst_off = st_q.burst_off;
        unique case (st_q.state)
            TS_IDLE: begin
                swap_sel       = cfg_swap_en;
                live_burst_off = cfg_burst_off;
                if (in_valid) begin
                    if (count == '0) begin
                        acc            = 1'b1;
                        disc           = live_burst_off || fills_up;
                        st_d.burst_off = cfg_burst_off;
                        st_d.swap      = cfg_swap_en;
                    end else begin
                        disc = 1'b1;
                    end
                end
            end
            TS_ACTIVE: begin
                if (in_valid) begin
                    acc  = 1'b1;
                    disc = live_burst_off || fills_up;
                end
            end
            TS_IGNORE: begin
                if (in_valid) begin
                    disc = 1'b1;
                end
            end
            default: begin
                acc  = 1'b0;
                disc = 1'b0;
            end
        endcase

        if (in_valid) begin
            if (in_last) begin
                st_d.state = TS_IDLE;
            end else if (disc) begin
                st_d.state = TS_IGNORE;
            end else begin
                st_d.state = TS_ACTIVE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: TS_IDLE, burst_off: 1'b0, swap: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/twb_top.sv
module twb_top #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_burst_off,
    input  logic                cfg_swap_en,
    input  logic                in_valid,
    input  logic                in_last,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [DATA_W/8-1:0] in_be,
    output logic                wr_acc,
    output logic                wr_disc,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   out_data,
    output logic [DATA_W/8-1:0] out_be
);
    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              swap_sel;
    logic              in_txn;
    logic              pop;
    logic [CNT_W-1:0]  fill_cnt;
    logic [DATA_W-1:0] sw_data;
    logic [BE_W-1:0]   sw_be;

    twb_ctrl #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_last       (in_last),
        .cfg_burst_off (cfg_burst_off),
        .cfg_swap_en   (cfg_swap_en),
        .count         (fill_cnt),
        .pop           (pop),
        .acc           (wr_acc),
        .disc          (wr_disc),
        .swap_sel      (swap_sel),
        .in_txn        (in_txn)
    );

    twb_swap #(
        .DATA_W (DATA_W)
    ) swap_i (
        .en     (swap_sel),
        .data_i (in_data),
        .be_i   (in_be),
        .data_o (sw_data),
        .be_o   (sw_be)
    );

    twb_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_acc),
        .push_data (sw_data),
        .push_be   (sw_be),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_be    (out_be),
        .pop       (pop),
        .count     (fill_cnt)
    );
endmodule

// File: rtl/twb_chk.sv
module twb_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_burst_off,
    input logic              in_valid,
    input logic              in_last,
    input logic              wr_acc,
    input logic              wr_disc,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [CNT_W-1:0]  fill_cnt,
    input logic              in_txn
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= FULL_CNT); // R1

    AST_FULL_DISC: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && !(out_valid && out_ready) && fill_cnt == LAST_SLOT |-> wr_disc); // R1

    AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && !in_txn && cfg_burst_off |-> wr_disc); // R2

    AST_IGNORE_AFTER_DISC: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && wr_disc && !in_last |=> !wr_acc); // R3

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6

    AST_EMPTY_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && !in_txn |-> fill_cnt == '0); // R7

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !wr_acc && !wr_disc); // R10
endmodule

bind twb_top twb_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_burst_off (cfg_burst_off),
    .in_valid      (in_valid),
    .in_last       (in_last),
    .wr_acc        (wr_acc),
    .wr_disc       (wr_disc),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .fill_cnt      (fill_cnt),
    .in_txn        (in_txn)
);

// File: tb/twb_top_tb_top.sv
module twb_top_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_burst_off = 1'b0;
    logic        cfg_swap_en = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_be = '0;
    logic        wr_acc, wr_disc, out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_be;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [35:0] exp_q[$];

    always #4 clk = ~clk;

    twb_top #(.DATA_W(32), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_burst_off(cfg_burst_off),
        .cfg_swap_en(cfg_swap_en), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .in_be(in_be), .wr_acc(wr_acc), .wr_disc(wr_disc),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_be(out_be)
    );

    task automatic check(input bit ok, input string req, input logic [35:0] act,
                         input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] model(input logic [31:0] d, input logic [3:0] b,
                                          input bit sw);
        logic [31:0] rd;
        logic [3:0]  rb;
        for (int k = 0; k < 4; k++) begin
            rd[8*k +: 8] = sw ? d[8*(3-k) +: 8] : d[8*k +: 8];
            rb[k]        = sw ? b[3-k] : b[k];
        end
        return {rd, rb};
    endfunction

    // monitor: compare each drained word with the scoreboard head (R6)
    always begin
        @(negedge clk);
        #3;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected word", {out_data, out_be}, '0);
            end else begin
                logic [35:0] e;
                e = exp_q.pop_front();
                check({out_data, out_be} == e, "R6/R4/R5 drain order+data",
                      {out_data, out_be}, e);
            end
        end
    end

    // driver: n phases, accept expected for i<n_acc, disc for i>=disc_from
    task automatic send_txn(input int n, input logic [31:0] base, input int n_acc,
                            input int disc_from, input bit exp_sw, input int flip_at,
                            input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == flip_at) begin
                cfg_swap_en   = ~cfg_swap_en;
                cfg_burst_off = ~cfg_burst_off;
            end
            in_valid = 1'b1;
            in_last  = (i == n - 1);
            in_data  = base + 32'(i) * 32'h0102_0304;
            in_be    = 4'(i + 1);
            #2;
            check(wr_acc == (i < n_acc), {req, " accept"}, 36'(wr_acc), 36'(i < n_acc));
            check(wr_disc == (disc_from >= 0 && i >= disc_from), {req, " disconnect"},
                  36'(wr_disc), 36'(disc_from >= 0 && i >= disc_from));
            if (i < n_acc) exp_q.push_back(model(in_data, in_be, exp_sw));
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain_all(input bit keep_ready);
        @(negedge clk);
        out_ready = 1'b1;
        for (int t = 0; t < 100 && exp_q.size() != 0; t++) @(negedge clk);
        check(exp_q.size() == 0, "R6 all drained", 36'(exp_q.size()), '0);
        repeat (2) @(negedge clk);
        check(!out_valid, "R6 buffer empty", 36'(out_valid), '0);
        out_ready = keep_ready;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R10 reset state
        check(!out_valid && !wr_acc && !wr_disc, "R10 reset state",
              {33'b0, out_valid, wr_acc, wr_disc}, '0);

        // R1 R4: burst fills buffer, disc on 4th, rest refused (R3)
        send_txn(6, 32'h1122_3344, DEPTH, DEPTH - 1, 1'b0, -1, "R1/R3 burst fill");
        @(negedge clk); #2;
        check({out_data, out_be} == exp_q[0], "R6 hold head",
              {out_data, out_be}, exp_q[0]);
        @(negedge clk); #2;
        check(out_valid && {out_data, out_be} == exp_q[0], "R6 hold while stalled",
              {out_data, out_be}, exp_q[0]);
        drain_all(1'b0);

        // R9: short burst ends with last, no disc
        send_txn(2, 32'hA0B0_C0D0, 2, -1, 1'b0, -1, "R9 short burst");
        drain_all(1'b0);

        // R2: single phase mode
        cfg_burst_off = 1'b1;
        send_txn(3, 32'h5566_7788, 1, 0, 1'b0, -1, "R2/R3 single phase");
        drain_all(1'b0);
        cfg_burst_off = 1'b0;

        // R5: swap
        cfg_swap_en = 1'b1;
        send_txn(2, 32'h1122_3344, 2, -1, 1'b1, -1, "R5 swap");
        drain_all(1'b0);
        cfg_swap_en = 1'b0;

        // R7: transaction while buffer not empty is refused
        send_txn(1, 32'hDEAD_0001, 1, -1, 1'b0, -1, "R7 leave word");
        send_txn(3, 32'hBEEF_0002, 0, 0, 1'b0, -1, "R7 retry");
        drain_all(1'b0);

        // R8: mid-transaction control change ignored
        send_txn(3, 32'h0A0B_0C0D, 3, -1, 1'b0, 1, "R8 mid change");
        drain_all(1'b0);
        cfg_swap_en   = 1'b0;
        cfg_burst_off = 1'b0;

        // R1/R9: concurrent drain keeps buffer from filling
        @(negedge clk);
        out_ready = 1'b1;
        send_txn(6, 32'h7000_0007, 6, -1, 1'b0, -1, "R1 drain in parallel");
        drain_all(1'b0);

        // R10: idle inputs give no accept or disconnect
        @(negedge clk); #2;
        check(!wr_acc && !wr_disc, "R10 idle quiet", {34'b0, wr_acc, wr_disc}, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule